// File: doc/BRIEF.md
# Pin-Interrupt GPIO Port

This block is one 8-bit general-purpose I/O port behind a small register interface. Three per-bit mode registers (direction, mode-select A and mode-select B) together choose how each pin behaves. It can be a push-pull output, an input, an output that only drives low, an output that only drives high, a level-sensitive interrupt source or an edge-triggered interrupt source. A per-bit data register supplies the driven value in the output modes. In the two interrupt modes it supplies the active level or the active edge instead.

Every pin input passes through a two-stage synchronizer. All further use of a pin, including reads of the data address, sees only the synchronized level. Edge events are held in per-pin flags until software clears them through a dedicated write-one-to-clear address. A single request output combines the live level requests with the held edge flags.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is asserted and right after it, direction reads 0xFF, mode-select A (address 2) and mode-select B (address 3) read 0x00, `pin_oe_o` is 0x00 and `irq_o` is 0. The data register must be written before it is relied on.
- R2: A write with `reg_we_i` high stores `reg_wdata_i` at its address: 0 data, 1 direction, 2 mode-select A, 3 mode-select B. Addresses 1 to 3 read back the stored value. Address 4 and any higher address read 0.
- R3: A read of address 0 returns the pin levels through two clocked stages. A change on `pin_i` set up before clock edge k appears on `reg_rdata_o` after edge k+1.
- R4: A pin's mode code is {B, A, direction}. With code 000, `pin_oe_o` is 1 and `pin_o` equals the data bit.
- R5: With code 010, `pin_o` is 0 and `pin_oe_o` is the inverse of the data bit. With code 011, `pin_o` is 1 and `pin_oe_o` equals the data bit.
- R6: Codes 001, 100, 101, 110 and 111 give `pin_oe_o`=0 and `pin_o`=0. Codes 110 and 111 never request an interrupt.
- R7: With code 100, a pin requests an interrupt for as long as its synchronized level equals its data bit. Nothing is latched.
- R8: With code 101, a pin's flag sets when two consecutive synchronized samples differ in the direction the data bit selects: 1 selects rising, 0 selects falling. The flag sets at the edge after the synchronized change, and it stays set until it is cleared.
- R9: Writing to address 4 clears the flag of every pin whose write-data bit is 1. Bits written as 0 leave their flags as they are.
- R10: If an edge is detected in the same cycle as a clear for that pin, the flag ends up set.
- R11: A pin that is not in code 101 has its flag cleared at the next clock edge. Returning the pin to code 101 does not bring the old flag back.
- R12: `irq_o` is the OR of all active level requests and all set edge flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from the address |
| pin_i | input | 8 | Pin input levels, asynchronous |
| pin_o | output | 8 | Pin output values |
| pin_oe_o | output | 8 | Pin output enables |
| irq_o | output | 1 | Port interrupt request |

## Verification
Register writes, output values and output enables take effect one edge after the write, because all of them decode combinationally from registers. A pin change is visible in read data and in level requests after two edges. An edge flag, and so `irq_o`, shows it after three edges.

The bench drives inputs on the falling clock edge and checks a short delay later. Its reference model advances on the same rising edges as the design, through its own two synchronizer stages, a previous-sample stage and a flag stage. Every output is therefore compared in exactly the cycle it becomes due. The directed checks name the specific cycle of each boundary: the last cycle still 0 and the first cycle that is 1.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIR  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_SELA = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_SELB = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CLR  = 3'd4;

  // mode code = {sel_b, sel_a, dir}
  typedef enum logic [2:0] {
    MODE_OUT   = 3'b000,
    MODE_IN    = 3'b001,
    MODE_ODRN  = 3'b010,
    MODE_OSRC  = 3'b011,
    MODE_LEVEL = 3'b100,
    MODE_EDGE  = 3'b101,
    MODE_RSV6  = 3'b110,
    MODE_RSV7  = 3'b111
  } pin_mode_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_reg_file.sv
module gpio_reg_file
  import gpio_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [WIDTH-1:0]  pin_sync_i,
  output logic [WIDTH-1:0]  data_o,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  sela_o,
  output logic [WIDTH-1:0]  selb_o,
  output logic [WIDTH-1:0]  clr_o,
  output logic [WIDTH-1:0]  rdata_o
);
  logic [WIDTH-1:0] data_q, dir_q, sela_q, selb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      dir_q  <= '1;
      sela_q <= '0;
      selb_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        ADDR_DATA: data_q <= wdata_i;
        ADDR_DIR:  dir_q  <= wdata_i;
        ADDR_SELA: sela_q <= wdata_i;
        ADDR_SELB: selb_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign clr_o = (we_i && addr_i == ADDR_CLR) ? wdata_i : '0;

  always_comb begin
    unique case (addr_i)
      ADDR_DATA: rdata_o = pin_sync_i;  // data address reads pins, not the latch
      ADDR_DIR:  rdata_o = dir_q;
      ADDR_SELA: rdata_o = sela_q;
      ADDR_SELB: rdata_o = selb_q;
      default:   rdata_o = '0;
    endcase
  end

  assign data_o = data_q;
  assign dir_o  = dir_q;
  assign sela_o = sela_q;
  assign selb_o = selb_q;

  p_dir_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_DIR) |=> (dir_q == $past(wdata_i)));
  p_data_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_DATA) |=> (data_q == $past(wdata_i)));
endmodule

// File: rtl/gpio_pin_slice.sv
module gpio_pin_slice
  import gpio_irq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pin_mode_e mode_i,
  input  logic      data_i,
  input  logic      level_i,
  input  logic      clr_i,
  output logic      pin_o,
  output logic      oe_o,
  output logic      req_o
);
  logic prev_q, flag_q, flag_d;
  logic is_edge, is_level, hit;

  assign is_edge  = (mode_i == MODE_EDGE);
  assign is_level = (mode_i == MODE_LEVEL);

  // data bit: 1 = rising / high active, 0 = falling / low active
  assign hit = is_edge && (data_i ? (level_i & ~prev_q) : (~level_i & prev_q));

  always_comb begin
    if (!is_edge)   flag_d = 1'b0;
    else if (hit)   flag_d = 1'b1;  // edge beats clear
    else if (clr_i) flag_d = 1'b0;
    else            flag_d = flag_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= level_i;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    unique case (mode_i)
      MODE_OUT:  begin pin_o = data_i; oe_o = 1'b1;    end
      MODE_ODRN: begin pin_o = 1'b0;   oe_o = ~data_i; end
      MODE_OSRC: begin pin_o = 1'b1;   oe_o = data_i;  end
      default:   begin pin_o = 1'b0;   oe_o = 1'b0;    end
    endcase
  end

  assign req_o = (is_level && (level_i == data_i)) || (is_edge && flag_q);

  p_no_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i inside {MODE_IN, MODE_LEVEL, MODE_EDGE, MODE_RSV6, MODE_RSV7}) |-> (!oe_o && !pin_o));
  p_rsv_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i inside {MODE_RSV6, MODE_RSV7}) |-> !req_o);
  p_flag_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_edge && flag_q && !clr_i) |=> flag_q);
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_edge && clr_i && !hit) |=> !flag_q);
  p_edge_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && clr_i) |=> flag_q);
  p_leave_edge_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_edge |=> !flag_q);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [WIDTH-1:0]  reg_wdata_i,
  output logic [WIDTH-1:0]  reg_rdata_o,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pin_o,
  output logic [WIDTH-1:0]  pin_oe_o,
  output logic              irq_o
);
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] data_q, dir_q, sela_q, selb_q, clr;
  logic [WIDTH-1:0] req;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  gpio_reg_file #(.WIDTH(WIDTH)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .pin_sync_i (pin_sync),
    .data_o     (data_q),
    .dir_o      (dir_q),
    .sela_o     (sela_q),
    .selb_o     (selb_q),
    .clr_o      (clr),
    .rdata_o    (reg_rdata_o)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    pin_mode_e mode;
    assign mode = pin_mode_e'({selb_q[i], sela_q[i], dir_q[i]});

    gpio_pin_slice u_slice (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .mode_i  (mode),
      .data_i  (data_q[i]),
      .level_i (pin_sync[i]),
      .clr_i   (clr[i]),
      .pin_o   (pin_o[i]),
      .oe_o    (pin_oe_o[i]),
      .req_o   (req[i])
    );
  end

  assign irq_o = |req;

  p_irq_needs_irq_mode_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|(selb_q & ~sela_q)));
endmodule

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] pin = 8'h00;
  logic [7:0] rdata, pout, poe;
  logic       irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_port u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .pin_i       (pin),
    .pin_o       (pout),
    .pin_oe_o    (poe),
    .irq_o       (irq)
  );

  // reference model, from the requirements
  logic [7:0] m_data, m_dir, m_sa, m_sb, m_s1, m_s2, m_prev, m_flag;
  logic [7:0] nf;

  function automatic logic [2:0] mode_of(int i);
    return {m_sb[i], m_sa[i], m_dir[i]};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_data <= 8'h00; m_dir <= 8'hFF; m_sa <= 8'h00; m_sb <= 8'h00;
      m_s1 <= 8'h00; m_s2 <= 8'h00; m_prev <= 8'h00; m_flag <= 8'h00;
    end else begin
      for (int i = 0; i < 8; i++) begin
        logic h, c;
        if (mode_of(i) == 3'b101) begin
          h = m_data[i] ? (m_s2[i] & ~m_prev[i]) : (~m_s2[i] & m_prev[i]);
          c = we && addr == 3'd4 && wdata[i];
          nf[i] = h | (m_flag[i] & ~c);
        end else nf[i] = 1'b0;
      end
      m_flag <= nf;
      m_s1 <= pin; m_s2 <= m_s1; m_prev <= m_s2;
      if (we) begin
        case (addr)
          3'd0: m_data <= wdata;
          3'd1: m_dir  <= wdata;
          3'd2: m_sa   <= wdata;
          3'd3: m_sb   <= wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] exp_out();
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      case (mode_of(i))
        3'b000: r[i] = m_data[i];
        3'b011: r[i] = 1'b1;
        default: r[i] = 1'b0;
      endcase
    return r;
  endfunction

  function automatic logic [7:0] exp_oe();
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      case (mode_of(i))
        3'b000: r[i] = 1'b1;
        3'b010: r[i] = ~m_data[i];
        3'b011: r[i] = m_data[i];
        default: r[i] = 1'b0;
      endcase
    return r;
  endfunction

  function automatic logic exp_irq();
    logic r = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (mode_of(i) == 3'b100 && m_s2[i] == m_data[i]) r = 1'b1;
      if (mode_of(i) == 3'b101 && m_flag[i]) r = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_rdata(logic [2:0] a);
    case (a)
      3'd0: return m_s2;
      3'd1: return m_dir;
      3'd2: return m_sa;
      3'd3: return m_sb;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R4 R5 R6 pin_o", pout, exp_out());
    check("R4 R5 R6 pin_oe_o", poe, exp_oe());
    check("R7 R8 R12 irq_o", {7'd0, irq}, {7'd0, exp_irq()});
    check("R2 R3 reg_rdata_o", rdata, exp_rdata(addr));
  endtask

  // drive one cycle on the falling edge, check a delta later
  task automatic cyc(logic w, logic [2:0] a, logic [7:0] d, logic [7:0] p);
    @(negedge clk);
    we = w; addr = a; wdata = d; pin = p;
    #1 compare_all();
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    cyc(1'b1, a, d, pin);
  endtask

  task automatic idle(int n, logic [2:0] a);
    for (int k = 0; k < n; k++) cyc(1'b0, a, 8'h00, pin);
  endtask

  initial begin
    void'($urandom(32'd4242));
    // R1 reset state
    @(negedge clk);
    addr = 3'd1; #1;
    check("R1 dir reset", rdata, 8'hFF);
    check("R1 oe reset", poe, 8'h00);
    check("R1 irq reset", {7'd0, irq}, 8'h00);
    addr = 3'd2; #1 check("R1 sela reset", rdata, 8'h00);
    addr = 3'd3; #1 check("R1 selb reset", rdata, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    wr(3'd0, 8'h01);            // bit0 rising
    wr(3'd3, 8'h01);            // bit0 -> 101 edge
    idle(1, 3'd4);
    check("R2 clr addr reads 0", rdata, 8'h00);
    // R3 on bit1, R8/R10 on bit0
    cyc(1'b0, 3'd0, 8'h00, 8'h02);
    cyc(1'b0, 3'd0, 8'h00, 8'h03);
    check("R3 one edge later still 0", {7'd0, rdata[1]}, 8'h00);
    idle(1, 3'd0);
    check("R3 two edges later", {7'd0, rdata[1]}, 8'h01);
    check("R8 flag not yet set", {7'd0, irq}, 8'h00);
    wr(3'd4, 8'h01);            // clear coincides with detected edge
    idle(1, 3'd0);
    check("R10 edge beats clear", {7'd0, irq}, 8'h01);
    wr(3'd4, 8'hFE);
    idle(1, 3'd0);
    check("R9 zero bits keep flag", {7'd0, irq}, 8'h01);
    wr(3'd4, 8'h01);
    idle(1, 3'd0);
    check("R9 clear", {7'd0, irq}, 8'h00);
    // R11
    cyc(1'b0, 3'd0, 8'h00, 8'h02);
    cyc(1'b0, 3'd0, 8'h00, 8'h03);
    idle(3, 3'd0);
    check("R8 flag set by rise", {7'd0, irq}, 8'h01);
    wr(3'd3, 8'h00);
    idle(1, 3'd0);
    check("R11 leave edge mode", {7'd0, irq}, 8'h00);
    wr(3'd3, 8'h01);
    idle(1, 3'd0);
    check("R11 flag stays clear", {7'd0, irq}, 8'h00);
    // R7 level on bit2, active high
    wr(3'd0, 8'h05);
    wr(3'd1, 8'hFB);
    wr(3'd3, 8'h05);
    idle(1, 3'd0);
    check("R7 level inactive", {7'd0, irq}, 8'h00);
    cyc(1'b0, 3'd0, 8'h00, 8'h07);
    idle(2, 3'd0);
    check("R7 level active", {7'd0, irq}, 8'h01);
    cyc(1'b0, 3'd0, 8'h00, 8'h03);
    idle(2, 3'd0);
    check("R7 no latch", {7'd0, irq}, 8'h00);
    // R4 R5 R6
    wr(3'd3, 8'h00); wr(3'd2, 8'h00); wr(3'd1, 8'h00); wr(3'd0, 8'hA5);
    idle(1, 3'd1);
    check("R4 push-pull out", pout, 8'hA5);
    check("R4 push-pull oe", poe, 8'hFF);
    wr(3'd2, 8'hFF);
    idle(1, 3'd1);
    check("R5 drive-low out", pout, 8'h00);
    check("R5 drive-low oe", poe, 8'h5A);
    wr(3'd1, 8'hFF);
    idle(1, 3'd1);
    check("R5 drive-high out", pout, 8'hFF);
    check("R5 drive-high oe", poe, 8'hA5);
    wr(3'd3, 8'hFF);
    cyc(1'b0, 3'd1, 8'h00, 8'hA5);
    idle(3, 3'd1);
    check("R6 reserved oe", poe, 8'h00);
    check("R6 reserved irq", {7'd0, irq}, 8'h00);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic w;
      logic [2:0] a;
      logic [7:0] p;
      w = ($urandom_range(0, 9) < 3);
      a = 3'($urandom_range(0, 4));
      p = ($urandom_range(0, 3) == 0) ? (pin ^ 8'($urandom)) : pin;
      cyc(w, a, 8'($urandom), p);
    end

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule